// File: doc/BRIEF.md
# Auto-Indexed Controller Register Port

This block is the byte-wide register window of a disc data controller. A host first loads a 4-bit index and then issues byte reads or writes. The index selects one of sixteen registers, and the read and write maps are different. After an access to a register, the index steps to the next one, so a host can walk a whole group of registers with back-to-back accesses after a single index load.

The port stores the following registers:
- interface control
- a 16-bit byte count
- a 16-bit data address
- a 16-bit write address
- a 16-bit block pointer
- two control registers
- the derived status bytes

Header bytes are read from one of two header banks. Three side-effect accesses leave the block as one-cycle strobes: the transfer trigger, the acknowledge and the read of the last status byte. A write to the last index restores the defined values. The stored fields go out as plain control pins to the transfer and decoder logic, which lie outside this block.

Top module: `ctl_regport`

## Requirements
- R1: A write stores `wr_data` in the register its index selects, one cycle later on the outputs:
  - 1: interface control.
  - 2 and 3: byte count, low then high.
  - 4 and 5: data address, low then high.
  - 8 and 9: write address, low then high.
  - 10: control 0.
  - 11: control 1.
  - 12 and 13: block pointer, low then high.
  - Writes to 0 and 14 change no register.
- R2: `rd_data` is combinational on the current index:
  - 1: interface status, which reads 0xFF.
  - 2 and 3: byte count, low then high.
  - 8 and 9: block pointer, low then high.
  - 10 and 11: write address, low then high.
  - 15: status 3, which reads 0x80.
- R3: An access (read or write) at an index from 1 to 14 sets the index to that value plus one on the next cycle. An access at index 0 leaves the index unchanged.
- R4: A read at index 15 sets the index to 0.
- R5: A read at index 0 returns 0xFF. A read at index 13 (status 1) returns 0x00.
- R6: Reads at indexes 4 to 7 return header bytes 0 to 3. Bit 0 of control 1 selects the bank. Bank 0 holds 00 00 00 01 and bank 1 holds all zeros.
- R7: A write to control 0 sets status 0 (read at index 12) to the written value AND 0x80.
- R8: Status 2 (read at index 14) is recomputed on every write to either control register:
  - When control-0 bit 4 is 1, it equals control 1 AND 0x08.
  - When that bit is 0, it equals control 1 AND 0x0C.
- R9: A write at index 15 is a soft reset:
  - Interface control, both control registers, status 0 and status 2 become 0x00.
  - The index becomes 0.
  - Byte count, data address, write address and block pointer keep their values.
- R10: `trig_o`, `ack_o` and `stat3_rd_o` are high for exactly the one cycle after, respectively:
  - a write at index 6
  - a write at index 7
  - a read at index 15 without a write in the same cycle
- R11: The precedence among same-cycle inputs is:
  - A soft reset sets the index to 0, whatever `idx_ld` asks.
  - Otherwise, `idx_ld` loads `idx_ld_val` in place of the step.
  - A write in the same cycle as a read takes effect and suppresses the read's side effects.
- R12: A low `rst_n` sets all stored registers, including the four 16-bit ones, to zero. It also sets the index to 0 and clears the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_ld | input | 1 | Load the register index |
| idx_ld_val | input | 4 | Index value to load |
| wr_en | input | 1 | Byte write at the current index |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Byte read at the current index |
| rd_data | output | 8 | Read data for the current index |
| idx_o | output | 4 | Current register index |
| ifctrl_o | output | 8 | Interface control register |
| byte_cnt_o | output | 16 | Byte count |
| data_addr_o | output | 16 | Data address |
| wr_addr_o | output | 16 | Write address |
| blk_ptr_o | output | 16 | Block pointer |
| ctrl0_o | output | 8 | Control register 0 |
| ctrl1_o | output | 8 | Control register 1 |
| trig_o | output | 1 | Transfer trigger strobe |
| ack_o | output | 1 | Acknowledge strobe |
| stat3_rd_o | output | 1 | Status-3 read strobe |

## Verification
The assertions take the access strobes and the index-load value to be known values on every clock after reset. Their step and wrap properties exclude cycles in which `idx_ld` or a soft-reset write competes with the access. The stimulus first drives a directed walk through both maps, the control-bit combinations and the same-cycle conflicts. It then drives a pseudo-random mix of writes, reads, index loads and combined write-plus-read cycles, always with fully defined values. That mix lets random writes at index 15 soft-reset the block in mid-sequence.

// File: rtl/ctl_regport_pkg.sv
package ctl_regport_pkg;
  localparam int DW         = 8;
  localparam int IDX_W      = 4;
  localparam int NUM_BANKS  = 2;
  localparam int HDR_BYTES  = 4;
  localparam int NUM_PAIRS  = 4;

  // write-side indexes
  localparam logic [IDX_W-1:0] WI_IFCTL = 4'd1;
  localparam logic [IDX_W-1:0] WI_TRIG  = 4'd6;
  localparam logic [IDX_W-1:0] WI_ACK   = 4'd7;
  localparam logic [IDX_W-1:0] WI_CTL0  = 4'd10;
  localparam logic [IDX_W-1:0] WI_CTL1  = 4'd11;
  localparam logic [IDX_W-1:0] IDX_LAST = 4'd15;

  // bit fields and fixed values
  localparam int             AUTO_BIT   = 4;
  localparam int             BANK_BIT   = 0;
  localparam logic [DW-1:0]  ST0_MASK   = 8'h80;
  localparam logic [DW-1:0]  MODE_MASK  = 8'h08;
  localparam logic [DW-1:0]  MF_MASK    = 8'h0C;
  localparam logic [DW-1:0]  IFST_VAL   = 8'hFF;
  localparam logic [DW-1:0]  ST3_VAL    = 8'h80;
  localparam logic [DW-1:0]  EMPTY_VAL  = 8'hFF;

  typedef enum logic [1:0] {PR_CNT = 2'd0, PR_DADDR = 2'd1, PR_WADDR = 2'd2, PR_BPTR = 2'd3} pair_e;

  // write index of the low byte of each 16-bit register
  function automatic logic [IDX_W-1:0] pair_wr_base(input int p);
    case (p)
      0:       return 4'd2;
      1:       return 4'd4;
      2:       return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

  // header bank contents: bank 0 ends in 01, all else zero
  function automatic logic [DW-1:0] hdr_val(input int bank, input int byte_i);
    return (bank == 0 && byte_i == HDR_BYTES-1) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/regport_index.sv
module regport_index
  import ctl_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             access,
  input  logic             rd_wrap,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx <= '0;
    else if (soft_rst)         idx <= '0;
    else if (ld)               idx <= ld_val;
    else if (access && idx != '0)
      idx <= rd_wrap ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/regport_store.sv
module regport_store
  import ctl_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    ifctrl,
  output logic [DW-1:0]    ctrl0,
  output logic [DW-1:0]    ctrl1,
  output logic [DW-1:0]    stat0,
  output logic [DW-1:0]    stat2,
  output logic [2*DW-1:0]  pair_q [NUM_PAIRS]
);
  function automatic logic [DW-1:0] mode_of(input logic auto_m, input logic [DW-1:0] c1);
    return auto_m ? (c1 & MODE_MASK) : (c1 & MF_MASK);
  endfunction

  // 16-bit registers, kept across a soft reset
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam logic [IDX_W-1:0] LO = pair_wr_base(p);
    localparam logic [IDX_W-1:0] HI = LO + 1'b1;
    logic [2*DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && idx == LO) q[DW-1:0]    <= wr_data;
      else if (wr_en && idx == HI) q[2*DW-1:DW] <= wr_data;
    end
    assign pair_q[p] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifctrl <= '0; ctrl0 <= '0; ctrl1 <= '0; stat0 <= '0; stat2 <= '0;
    end else if (soft_rst) begin
      ifctrl <= '0; ctrl0 <= '0; ctrl1 <= '0; stat0 <= '0; stat2 <= '0;
    end else if (wr_en) begin
      case (idx)
        WI_IFCTL: ifctrl <= wr_data;
        WI_CTL0: begin
          ctrl0 <= wr_data;
          stat0 <= wr_data & ST0_MASK;
          stat2 <= mode_of(wr_data[AUTO_BIT], ctrl1);
        end
        WI_CTL1: begin
          ctrl1 <= wr_data;
          stat2 <= mode_of(ctrl0[AUTO_BIT], wr_data);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regport_rdmux.sv
module regport_rdmux
  import ctl_regport_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             bank_sel,
  input  logic [2*DW-1:0]  cnt,
  input  logic [2*DW-1:0]  wa,
  input  logic [2*DW-1:0]  pt,
  input  logic [DW-1:0]    stat0,
  input  logic [DW-1:0]    stat2,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] hdr_tab [NUM_BANKS][HDR_BYTES];
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_byte
      assign hdr_tab[b][k] = hdr_val(b, k);
    end
  end

  logic [1:0] hdr_k;
  assign hdr_k = idx[1:0];

  always_comb begin
    case (idx)
      4'd1:              rd_data = IFST_VAL;
      4'd2:              rd_data = cnt[DW-1:0];
      4'd3:              rd_data = cnt[2*DW-1:DW];
      4'd4, 4'd5,
      4'd6, 4'd7:        rd_data = hdr_tab[bank_sel][hdr_k];
      4'd8:              rd_data = pt[DW-1:0];
      4'd9:              rd_data = pt[2*DW-1:DW];
      4'd10:             rd_data = wa[DW-1:0];
      4'd11:             rd_data = wa[2*DW-1:DW];
      4'd12:             rd_data = stat0;
      4'd13:             rd_data = '0;
      4'd14:             rd_data = stat2;
      4'd15:             rd_data = ST3_VAL;
      default:           rd_data = EMPTY_VAL;
    endcase
  end
endmodule

// File: rtl/regport_strobe.sv
module regport_strobe
  import ctl_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  output logic             trig,
  output logic             ack,
  output logic             st3_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= 1'b0; ack <= 1'b0; st3_rd <= 1'b0;
    end else begin
      trig   <= wr_en && idx == WI_TRIG;
      ack    <= wr_en && idx == WI_ACK;
      st3_rd <= rd_en && !wr_en && idx == IDX_LAST;
    end
  end
endmodule

// File: rtl/ctl_regport.sv
module ctl_regport
  import ctl_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_ld,
  input  logic [IDX_W-1:0] idx_ld_val,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic [IDX_W-1:0] idx_o,
  output logic [DW-1:0]    ifctrl_o,
  output logic [2*DW-1:0]  byte_cnt_o,
  output logic [2*DW-1:0]  data_addr_o,
  output logic [2*DW-1:0]  wr_addr_o,
  output logic [2*DW-1:0]  blk_ptr_o,
  output logic [DW-1:0]    ctrl0_o,
  output logic [DW-1:0]    ctrl1_o,
  output logic             trig_o,
  output logic             ack_o,
  output logic             stat3_rd_o
);
  logic soft_rst, rd_wrap;
  logic [DW-1:0]   stat0, stat2;
  logic [2*DW-1:0] pair_q [NUM_PAIRS];

  assign soft_rst = wr_en && idx_o == IDX_LAST;
  assign rd_wrap  = rd_en && !wr_en && idx_o == IDX_LAST;

  regport_index u_index (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ld(idx_ld), .ld_val(idx_ld_val),
    .access(wr_en || rd_en), .rd_wrap(rd_wrap), .idx(idx_o)
  );

  regport_store u_store (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .idx(idx_o),
    .wr_data(wr_data), .ifctrl(ifctrl_o), .ctrl0(ctrl0_o), .ctrl1(ctrl1_o),
    .stat0(stat0), .stat2(stat2), .pair_q(pair_q)
  );

  assign byte_cnt_o  = pair_q[PR_CNT];
  assign data_addr_o = pair_q[PR_DADDR];
  assign wr_addr_o   = pair_q[PR_WADDR];
  assign blk_ptr_o   = pair_q[PR_BPTR];

  regport_rdmux u_rdmux (
    .idx(idx_o), .bank_sel(ctrl1_o[BANK_BIT]), .cnt(pair_q[PR_CNT]),
    .wa(pair_q[PR_WADDR]), .pt(pair_q[PR_BPTR]), .stat0(stat0), .stat2(stat2),
    .rd_data(rd_data)
  );

  regport_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx_o),
    .trig(trig_o), .ack(ack_o), .st3_rd(stat3_rd_o)
  );
endmodule

// File: rtl/ctl_regport_chk.sv
module ctl_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_ld,
  input logic [3:0] idx_ld_val,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic [3:0] idx_o,
  input logic [7:0] ifctrl_o,
  input logic [7:0] ctrl0_o,
  input logic [7:0] ctrl1_o,
  input logic       trig_o
);
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !idx_ld && idx_o != 4'd0 && idx_o != 4'd15 |=> idx_o == $past(idx_o) + 4'd1);

  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ld && idx_o == 4'd0 |=> idx_o == 4'd0);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && !idx_ld && idx_o == 4'd15 |=> idx_o == 4'd0);

  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && idx_o == 4'd0 |-> rd_data == 8'hFF);

  p_stat1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && idx_o == 4'd13 |-> rd_data == 8'h00);

  p_ctrl0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_o == 4'd10 |=> ctrl0_o == $past(wr_data));

  p_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_o == 4'd15 |=> idx_o == 4'd0 && ctrl0_o == 8'h00 && ctrl1_o == 8'h00 && ifctrl_o == 8'h00);

  p_trig_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx_o == 4'd6 |=> trig_o);

  p_trig_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx_o == 4'd6) |=> !trig_o);

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld && !(wr_en && idx_o == 4'd15) |=> idx_o == $past(idx_ld_val));
endmodule

bind ctl_regport ctl_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_ld_val(idx_ld_val),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
  .idx_o(idx_o), .ifctrl_o(ifctrl_o), .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o),
  .trig_o(trig_o)
);

// File: tb/ctl_regport_bench.sv
`timescale 1ns/100ps
module ctl_regport_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_ld = 1'b0;
  logic [3:0] idx_ld_val = 4'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] idx_o;
  logic [7:0] ifctrl_o, ctrl0_o, ctrl1_o;
  logic [15:0] byte_cnt_o, data_addr_o, wr_addr_o, blk_ptr_o;
  logic trig_o, ack_o, stat3_rd_o;

  always #2.5 clk = ~clk;

  ctl_regport u_ctl_regport (
    .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_ld_val(idx_ld_val),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .idx_o(idx_o), .ifctrl_o(ifctrl_o), .byte_cnt_o(byte_cnt_o),
    .data_addr_o(data_addr_o), .wr_addr_o(wr_addr_o), .blk_ptr_o(blk_ptr_o),
    .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .trig_o(trig_o), .ack_o(ack_o),
    .stat3_rd_o(stat3_rd_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [3:0]  m_idx;
  logic [7:0]  m_ifctrl, m_c0, m_c1, m_s0, m_s2;
  logic [15:0] m_cnt, m_dac, m_wa, m_pt;
  logic        m_trig, m_ack, m_st3;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_hw_reset();
    m_idx = 4'd0; m_ifctrl = 8'd0; m_c0 = 8'd0; m_c1 = 8'd0; m_s0 = 8'd0; m_s2 = 8'd0;
    m_cnt = 16'd0; m_dac = 16'd0; m_wa = 16'd0; m_pt = 16'd0;
    m_trig = 1'b0; m_ack = 1'b0; m_st3 = 1'b0;
  endtask

  function automatic logic [7:0] mode_bits(input logic auto_m, input logic [7:0] c1);
    return auto_m ? (c1 & 8'h08) : (c1 & 8'h0C);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] i);
    case (i)
      4'd0, 4'd1: return 8'hFF;
      4'd2:  return m_cnt[7:0];
      4'd3:  return m_cnt[15:8];
      4'd4, 4'd5, 4'd6: return 8'h00;
      4'd7:  return m_c1[0] ? 8'h00 : 8'h01;
      4'd8:  return m_pt[7:0];
      4'd9:  return m_pt[15:8];
      4'd10: return m_wa[7:0];
      4'd11: return m_wa[15:8];
      4'd12: return m_s0;
      4'd13: return 8'h00;
      4'd14: return m_s2;
      default: return 8'h80;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] i);
    if (i == 4'd0 || i == 4'd13) return "R5 fixed read";
    if (i >= 4'd4 && i <= 4'd7)  return "R6 header byte";
    if (i == 4'd12)              return "R7 status0";
    if (i == 4'd14)              return "R8 status2";
    return "R2 read map";
  endfunction

  task automatic model_step(input logic w, input logic [7:0] d, input logic r,
                            input logic l, input logic [3:0] lv);
    if (w && m_idx == 4'd15) begin
      m_ifctrl = 8'd0; m_c0 = 8'd0; m_c1 = 8'd0; m_s0 = 8'd0; m_s2 = 8'd0;
      m_idx = 4'd0; m_trig = 1'b0; m_ack = 1'b0; m_st3 = 1'b0;
    end else begin
      m_trig = w && m_idx == 4'd6;
      m_ack  = w && m_idx == 4'd7;
      m_st3  = r && !w && m_idx == 4'd15;
      if (w) begin
        case (m_idx)
          4'd1:  m_ifctrl = d;
          4'd2:  m_cnt[7:0] = d;
          4'd3:  m_cnt[15:8] = d;
          4'd4:  m_dac[7:0] = d;
          4'd5:  m_dac[15:8] = d;
          4'd8:  m_wa[7:0] = d;
          4'd9:  m_wa[15:8] = d;
          4'd10: begin m_c0 = d; m_s0 = d & 8'h80; m_s2 = mode_bits(d[4], m_c1); end
          4'd11: begin m_c1 = d; m_s2 = mode_bits(m_c0[4], d); end
          4'd12: m_pt[7:0] = d;
          4'd13: m_pt[15:8] = d;
          default: ;
        endcase
      end
      if (l) m_idx = lv;
      else if ((w || r) && m_idx != 4'd0)
        m_idx = (r && !w && m_idx == 4'd15) ? 4'd0 : m_idx + 4'd1;
    end
  endtask

  task automatic compare_all();
    chk("R3 index", 32'(idx_o), 32'(m_idx));
    chk("R1 ifctrl", 32'(ifctrl_o), 32'(m_ifctrl));
    chk("R1 byte count", 32'(byte_cnt_o), 32'(m_cnt));
    chk("R1 data address", 32'(data_addr_o), 32'(m_dac));
    chk("R1 write address", 32'(wr_addr_o), 32'(m_wa));
    chk("R1 block pointer", 32'(blk_ptr_o), 32'(m_pt));
    chk("R1 ctrl0", 32'(ctrl0_o), 32'(m_c0));
    chk("R1 ctrl1", 32'(ctrl1_o), 32'(m_c1));
    chk("R10 trig strobe", 32'(trig_o), 32'(m_trig));
    chk("R10 ack strobe", 32'(ack_o), 32'(m_ack));
    chk("R10 status3 strobe", 32'(stat3_rd_o), 32'(m_st3));
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic r,
                     input logic l, input logic [3:0] lv);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; idx_ld = l; idx_ld_val = lv;
    #1;
    if (r) chk(rd_tag(m_idx), 32'(rd_data), 32'(exp_rd(m_idx)));
    @(posedge clk); #1;
    model_step(w, d, r, l, lv);
    compare_all();
  endtask

  task automatic wr(input logic [7:0] d);  cyc(1'b1, d, 1'b0, 1'b0, 4'd0); endtask
  task automatic rd();                      cyc(1'b0, 8'd0, 1'b1, 1'b0, 4'd0); endtask
  task automatic ld(input logic [3:0] v);   cyc(1'b0, 8'd0, 1'b0, 1'b1, v);    endtask
  task automatic idle();                    cyc(1'b0, 8'd0, 1'b0, 1'b0, 4'd0); endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; idx_ld = 1'b0;
    @(posedge clk); #1;
    model_hw_reset();
    chk("R12 reset read idx0", 32'(rd_data), 32'hFF);
    compare_all();
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_hw_reset();
    hw_reset();
    idle();
    // R5: index 0 read, no step (R3)
    rd(); rd();
    // R1: walk the write map from index 1
    ld(4'd1);
    wr(8'h5A); wr(8'h34); wr(8'h12); wr(8'hCD); wr(8'hAB);
    wr(8'h00);            // R10 trigger
    wr(8'h00);            // R10 acknowledge
    wr(8'h78); wr(8'h56);
    wr(8'h90);            // R7/R8 ctrl0 with auto bit
    wr(8'h0D);            // ctrl1, bank 1 selected
    wr(8'hEF); wr(8'hBE);
    wr(8'hEE);            // index 14 ignored
    idle();
    // R2/R6/R4: walk the read map and wrap
    ld(4'd1);
    for (int i = 1; i <= 15; i++) rd();
    rd();                 // now at 0
    // R8: clear auto bit, then new ctrl1 picks bank 0 (R6)
    ld(4'd10); wr(8'h00); wr(8'h04);
    ld(4'd4); rd(); rd(); rd(); rd();
    ld(4'd12); rd(); rd(); rd();
    ld(4'd10); wr(8'h10);
    ld(4'd14); rd();
    // R11: write beats read in same cycle, load beats step
    ld(4'd6); cyc(1'b1, 8'h00, 1'b1, 1'b0, 4'd0);
    ld(4'd15); cyc(1'b1, 8'h22, 1'b1, 1'b0, 4'd0);   // soft reset, no status3 strobe
    ld(4'd2); cyc(1'b1, 8'h99, 1'b0, 1'b1, 4'd9);
    ld(4'd15); cyc(1'b1, 8'h00, 1'b0, 1'b1, 4'd5);   // R9 soft reset wins over load
    // R9: pointers kept, then read them back
    ld(4'd2); rd(); rd();
    ld(4'd8); for (int i = 0; i < 4; i++) rd();
    ld(4'd15); rd();      // R10 status3 strobe, R4 wrap
    idle();
    // R12 mid-run hardware reset
    hw_reset();
    idle();
    ld(4'd8); rd(); rd();
    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: wr(lfsr[15:8]);
        2'd1: rd();
        2'd2: ld(lfsr[7:4]);
        default: cyc(1'b1, lfsr[15:8], 1'b1, lfsr[2] & lfsr[3], lfsr[7:4]);
      endcase
    end
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule